// File: doc/BRIEF.md
# Eight-Entry Evaluation Stack Unit

This block holds a small last-in-first-out operand stack of 16-bit words in eight registers, with a pointer that counts how many cells are in use. A zero count means the stack is empty, and a count of eight means it is full. A controller drives one command at a time. Commands can push a word from the data input or from memory, and pop the top word to the data output or to memory. Double-word commands move a pair of words between memory and the stack at two adjacent addresses.

Memory addresses are formed from a base and an 8-bit offset. A single-word memory command uses `base + offset`. A double-word command uses `hi = base + offset + 1` and `hi - 1`. A double push reads `hi - 1` first and `hi` second, so the word from `hi` ends on top. A double pop writes the top word to `hi` and then the next word to `hi - 1`.

A command that would overfill or over-empty the stack is refused. It does not touch the cells, the count or memory, and it reports a one-cycle trap together with the completion strobe. The top word and the count are visible at all times.

Top module: `evs_stack`

## Requirements
- R1: While reset is held and just after it, depth is 0, and done, busy, both traps and the memory request are all low.
- R2: Command code 0 pushes `cmd_data` into the cell indexed by the old depth. Depth rises by one, the new word appears on `tos_o`, and done is high in the first cycle after the command is accepted.
- R3: Command code 2 removes the top word, places it on `pop_data_o` and lowers depth by one, so words leave in the reverse of their push order.
- R4: A single push (code 0 or 1) at depth 8 writes nothing and pulses `trap_ovf_o` together with done. Depth and the top word are unchanged.
- R5: A single pop (code 2 or 3) at depth 0 pulses `trap_unf_o` together with done. Depth stays 0.
- R6: Command code 1 reads memory at `base + offset` and pushes the read word. Done follows two cycles after acceptance.
- R7: Command code 3 writes the top word to memory at `base + offset` and lowers depth by one. Done follows two cycles after acceptance.
- R8: Command code 4 reads `base + offset` and then `base + offset + 1`, pushing them in that order. Depth rises by 2, the second word is on top, and done follows three cycles after acceptance.
- R9: Command code 5 writes the top word to `base + offset + 1` and then the word below it to `base + offset`. Depth falls by 2, and done follows three cycles after acceptance.
- R10: Command code 4 at depth above 6 raises the overflow trap, and command code 5 at depth below 2 raises the underflow trap. In both cases no memory cycle occurs, the state is unchanged, and done comes in the first cycle.
- R11: While `busy_o` is high, a command presented on `cmd_valid` is ignored and produces no completion.
- R12: The memory request is only raised while the unit is busy. Read data is taken in a cycle where `mem_req_o` is high and `mem_we_o` is low, and a write happens at the end of a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0..5) |
| cmd_base | input | 16 | Base address |
| cmd_ofs | input | 8 | Address offset |
| cmd_data | input | 16 | Word for a push from input |
| busy_o | output | 1 | A memory command is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pop_data_o | output | 16 | Word removed by the last pop to output |
| trap_ovf_o | output | 1 | Overflow trap strobe |
| trap_unf_o | output | 1 | Underflow trap strobe |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid in the request cycle |
| tos_o | output | 16 | Top word, 0 when empty |
| depth_o | output | 4 | Number of occupied cells |

## Verification
The bench drives the stack to both ends. It pushes at full depth, pops at empty, tries a double push at depth 7 and 8, and tries a double pop at depth 0 and 1. An off-by-one limit check would either corrupt a cell with a stray write or refuse a legal command. For the double-word moves, the bench compares the resulting stack order and the two memory locations against a model. Swapped words or an address without the `+1` would leave the wrong word on top or write to the wrong cell. The bench also issues a command while a double push is in progress; a unit that accepted it would show an extra done strobe and an extra entry.

// File: rtl/evs_pkg.sv
package evs_pkg;

    typedef enum logic [2:0] {
        OP_PUSH_IN  = 3'd0,
        OP_PUSH_MEM = 3'd1,
        OP_POP_OUT  = 3'd2,
        OP_POP_MEM  = 3'd3,
        OP_DPUSH    = 3'd4,
        OP_DPOP     = 3'd5
    } evs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_RD2  = 3'd2,
        ST_WR1  = 3'd3,
        ST_WR2  = 3'd4
    } evs_state_e;

endpackage

// File: rtl/evs_addr_gen.sv
module evs_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] lo_o,
    output logic [ADDR_W-1:0] hi_o
);
    // Low word sits at base+offset, the high word one above it.
    assign lo_o = base_i + ADDR_W'(ofs_i);
    assign hi_o = lo_o + ADDR_W'(1);
endmodule

// File: rtl/evs_cells.sv
module evs_cells #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DEPTH-1:0][DATA_W-1:0] view;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                val_q <= wr_data;
            end
        end
        assign view[g] = val_q;
    end

    assign rd_data = view[rd_idx];
endmodule

// File: rtl/evs_stack.sv
module evs_stack
    import evs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [OFS_W-1:0]  cmd_ofs,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              trap_ovf_o,
    output logic              trap_unf_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] tos_o,
    output logic [PTR_W-1:0]  depth_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] TWO  = PTR_W'(2);

    typedef struct packed {
        evs_state_e        st;
        logic              dbl;
        logic [PTR_W-1:0]  sp;
        logic              done;
        logic              ovf;
        logic              unf;
        logic [DATA_W-1:0] pop;
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] nxt_addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] lo_addr, hi_addr;
    logic              cell_we;
    logic [IDX_W-1:0]  cell_widx;
    logic [DATA_W-1:0] cell_wdata;
    logic [IDX_W-1:0]  top_idx;
    logic [DATA_W-1:0] top_val;

    evs_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .base_i (cmd_base),
        .ofs_i  (cmd_ofs),
        .lo_o   (lo_addr),
        .hi_o   (hi_addr)
    );

    assign top_idx = IDX_W'(ctl_q.sp - ONE);

    evs_cells #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cell_we),
        .wr_idx  (cell_widx),
        .wr_data (cell_wdata),
        .rd_idx  (top_idx),
        .rd_data (top_val)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.ovf  = 1'b0;
        ctl_d.unf  = 1'b0;
        cell_we    = 1'b0;
        cell_widx  = ctl_q.sp[IDX_W-1:0];
        cell_wdata = cmd_data;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (evs_op_e'(cmd_op))
                        OP_PUSH_IN: begin
                            ctl_d.done = 1'b1;
                            if (ctl_q.sp == FULL) begin
                                ctl_d.ovf = 1'b1;
                            end else begin
                                cell_we  = 1'b1;
                                ctl_d.sp = ctl_q.sp + ONE;
                            end
                        end
                        OP_PUSH_MEM, OP_DPUSH: begin
                            if ((cmd_op == OP_PUSH_MEM && ctl_q.sp == FULL) ||
                                (cmd_op == OP_DPUSH && ctl_q.sp > FULL - TWO)) begin
                                ctl_d.ovf  = 1'b1;
                                ctl_d.done = 1'b1;
                            end else begin
                                ctl_d.st       = ST_RD1;
                                ctl_d.dbl      = (cmd_op == OP_DPUSH);
                                ctl_d.req      = 1'b1;
                                ctl_d.we       = 1'b0;
                                ctl_d.addr     = lo_addr;
                                ctl_d.nxt_addr = hi_addr;
                            end
                        end
                        OP_POP_OUT: begin
                            ctl_d.done = 1'b1;
                            if (ctl_q.sp == '0) begin
                                ctl_d.unf = 1'b1;
                            end else begin
                                ctl_d.pop = top_val;
                                ctl_d.sp  = ctl_q.sp - ONE;
                            end
                        end
                        OP_POP_MEM, OP_DPOP: begin
                            if ((cmd_op == OP_POP_MEM && ctl_q.sp == '0) ||
                                (cmd_op == OP_DPOP && ctl_q.sp < TWO)) begin
                                ctl_d.unf  = 1'b1;
                                ctl_d.done = 1'b1;
                            end else begin
                                ctl_d.st       = ST_WR1;
                                ctl_d.dbl      = (cmd_op == OP_DPOP);
                                ctl_d.req      = 1'b1;
                                ctl_d.we       = 1'b1;
                                ctl_d.addr     = (cmd_op == OP_DPOP) ? hi_addr : lo_addr;
                                ctl_d.nxt_addr = lo_addr;
                                ctl_d.wdata    = top_val;
                                ctl_d.sp       = ctl_q.sp - ONE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_RD1: begin
                cell_we    = 1'b1;
                cell_wdata = mem_rdata_i;
                ctl_d.sp   = ctl_q.sp + ONE;
                if (ctl_q.dbl) begin
                    ctl_d.addr = ctl_q.nxt_addr;
                    ctl_d.st   = ST_RD2;
                end else begin
                    ctl_d.req  = 1'b0;
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            ST_RD2: begin
                cell_we    = 1'b1;
                cell_wdata = mem_rdata_i;
                ctl_d.sp   = ctl_q.sp + ONE;
                ctl_d.req  = 1'b0;
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end
            ST_WR1: begin
                if (ctl_q.dbl) begin
                    ctl_d.addr  = ctl_q.nxt_addr;
                    ctl_d.wdata = top_val;
                    ctl_d.sp    = ctl_q.sp - ONE;
                    ctl_d.st    = ST_WR2;
                end else begin
                    ctl_d.req  = 1'b0;
                    ctl_d.we   = 1'b0;
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            ST_WR2: begin
                ctl_d.req  = 1'b0;
                ctl_d.we   = 1'b0;
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign done_o      = ctl_q.done;
    assign pop_data_o  = ctl_q.pop;
    assign trap_ovf_o  = ctl_q.ovf;
    assign trap_unf_o  = ctl_q.unf;
    assign mem_req_o   = ctl_q.req;
    assign mem_we_o    = ctl_q.we;
    assign mem_addr_o  = ctl_q.addr;
    assign mem_wdata_o = ctl_q.wdata;
    assign tos_o       = (ctl_q.sp == '0) ? '0 : top_val;
    assign depth_o     = ctl_q.sp;
endmodule

// File: rtl/evs_stack_chk.sv
module evs_stack_chk #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             trap_ovf_o,
    input logic             trap_unf_o,
    input logic             mem_req_o,
    input logic [PTR_W-1:0] depth_o
);
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= PTR_W'(DEPTH)); // R2

    AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ovf_o |-> $stable(depth_o)); // R4

    AST_UNF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_unf_o |-> $stable(depth_o)); // R5

    AST_OVF_NEAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ovf_o |-> (depth_o >= PTR_W'(DEPTH - 1))); // R10

    AST_UNF_NEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        trap_unf_o |-> (depth_o <= PTR_W'(1))); // R10

    AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ovf_o || trap_unf_o) |-> (done_o && !(trap_ovf_o && trap_unf_o))); // R10

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o); // R12

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R11
endmodule

bind evs_stack evs_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .trap_ovf_o (trap_ovf_o),
    .trap_unf_o (trap_unf_o),
    .mem_req_o  (mem_req_o),
    .depth_o    (depth_o)
);

// File: tb/evs_stack_test.sv
module evs_stack_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_base = '0;
    logic [7:0]  cmd_ofs = '0;
    logic [15:0] cmd_data = '0;
    logic        busy_o, done_o, trap_ovf_o, trap_unf_o, mem_req_o, mem_we_o;
    logic [15:0] pop_data_o, mem_addr_o, mem_wdata_o, mem_rdata_i, tos_o;
    logic [3:0]  depth_o;

    logic [15:0] mem [256];
    logic [15:0] model [$];

    typedef struct {
        string       tag;
        logic        ovf;
        logic        unf;
        logic        chk_pop;
        logic [15:0] pop;
        logic [15:0] tos;
        logic [3:0]  depth;
    } exp_t;
    exp_t sb [$];

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evs_stack uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_base(cmd_base), .cmd_ofs(cmd_ofs), .cmd_data(cmd_data),
        .busy_o(busy_o), .done_o(done_o), .pop_data_o(pop_data_o),
        .trap_ovf_o(trap_ovf_o), .trap_unf_o(trap_unf_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .tos_o(tos_o), .depth_o(depth_o)
    );

    // Memory model: read data in the request cycle, write at the edge.
    assign mem_rdata_i = mem[mem_addr_o[7:0]];
    always @(posedge clk) begin
        if (mem_req_o && mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each completion against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check("R11", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "overflow trap", 32'(trap_ovf_o), 32'(e.ovf));
                check(e.tag, "underflow trap", 32'(trap_unf_o), 32'(e.unf));
                check(e.tag, "depth", 32'(depth_o), 32'(e.depth));
                check(e.tag, "top word", 32'(tos_o), 32'(e.tos));
                if (e.chk_pop) check(e.tag, "popped word", 32'(pop_data_o), 32'(e.pop));
            end
        end
    end

    // Driver: computes the expected result, queues it, issues the command.
    task automatic do_op(input logic [2:0] op, input logic [15:0] base,
                         input logic [7:0] ofs, input logic [15:0] data,
                         input string tag, input bit intrude, output int lat);
        exp_t e;
        logic [7:0] lo;
        lo = 8'(base + 16'(ofs));
        e.tag = tag; e.ovf = 0; e.unf = 0; e.chk_pop = 0; e.pop = '0;
        case (op)
            3'd0: if (model.size() == 8) e.ovf = 1; else model.push_back(data);
            3'd1: if (model.size() == 8) e.ovf = 1; else model.push_back(mem[lo]);
            3'd2: if (model.size() == 0) e.unf = 1;
                  else begin e.chk_pop = 1; e.pop = model.pop_back(); end
            3'd3: if (model.size() == 0) e.unf = 1; else void'(model.pop_back());
            3'd4: if (model.size() > 6) e.ovf = 1;
                  else begin model.push_back(mem[lo]); model.push_back(mem[8'(lo + 8'd1)]); end
            3'd5: if (model.size() < 2) e.unf = 1;
                  else begin void'(model.pop_back()); void'(model.pop_back()); end
            default: ;
        endcase
        e.depth = 4'(model.size());
        e.tos = (model.size() == 0) ? 16'h0 : model[$];
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_base = base; cmd_ofs = ofs; cmd_data = data;
        @(negedge clk);
        lat = 1;
        cmd_valid = intrude; cmd_op = 3'd0; cmd_data = 16'hDEAD;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            cmd_valid = 0;
            lat++;
        end
        cmd_valid = 0;
        if (!done_o) check(tag, "completion seen", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int lat;
        logic [15:0] w_hi, w_lo;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i) ^ 16'h5A00;
        mem[8'h20] = 16'hAAAA;
        mem[8'h21] = 16'hBBBB;

        repeat (3) @(negedge clk);
        check("R1", "depth in reset", 32'(depth_o), 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "depth after reset", 32'(depth_o), 32'd0);
        check("R1", "done/busy/traps/req", {28'd0, done_o, busy_o, trap_ovf_o | trap_unf_o, mem_req_o}, 32'd0);

        do_op(3'd2, 0, 0, 0, "R5", 0, lat);
        do_op(3'd3, 16'h10, 0, 0, "R5", 0, lat);
        do_op(3'd5, 16'h10, 0, 0, "R10", 0, lat);
        check("R10", "double pop refusal latency", 32'(lat), 32'd1);

        for (int i = 0; i < 8; i++) begin
            do_op(3'd0, 0, 0, 16'h1000 + 16'(i * 17), "R2", 0, lat);
            if (i == 0) check("R2", "push latency", 32'(lat), 32'd1);
        end
        do_op(3'd0, 0, 0, 16'hFFFF, "R4", 0, lat);
        do_op(3'd1, 16'h20, 0, 0, "R4", 0, lat);
        do_op(3'd4, 16'h10, 0, 0, "R10", 0, lat);
        check("R10", "double push refusal latency", 32'(lat), 32'd1);
        for (int i = 0; i < 8; i++) do_op(3'd2, 0, 0, 0, "R3", 0, lat);

        do_op(3'd1, 16'h10, 8'h10, 0, "R6", 0, lat);
        check("R6", "push from memory latency", 32'(lat), 32'd2);
        check("R6", "word read from base+offset", 32'(tos_o), 32'h0000AAAA);

        do_op(3'd4, 16'h18, 8'h08, 0, "R8", 0, lat);
        check("R8", "double push latency", 32'(lat), 32'd3);
        check("R8", "upper word on top", 32'(tos_o), 32'h0000BBBB);

        do_op(3'd4, 16'h40, 8'h02, 0, "R11", 1, lat);
        repeat (2) @(negedge clk);
        check("R11", "no completion after ignored command", 32'(done_o), 32'd0);
        check("R11", "depth after ignored command", 32'(depth_o), 32'd5);

        w_hi = model[$]; w_lo = model[$-1];
        do_op(3'd5, 16'h60, 8'h0F, 0, "R9", 0, lat);
        check("R9", "double pop latency", 32'(lat), 32'd3);
        check("R9", "top word at base+offset+1", 32'(mem[8'h70]), 32'(w_hi));
        check("R9", "second word at base+offset", 32'(mem[8'h6F]), 32'(w_lo));

        w_hi = model[$];
        do_op(3'd3, 16'h80, 8'h01, 0, "R7", 0, lat);
        check("R7", "pop to memory latency", 32'(lat), 32'd2);
        check("R7", "word written at base+offset", 32'(mem[8'h81]), 32'(w_hi));

        for (int i = 0; i < 5; i++) do_op(3'd0, 0, 0, 16'h2200 + 16'(i), "R2", 0, lat);
        check("R12", "depth before refused double push", 32'(depth_o), 32'd7);
        do_op(3'd4, 16'h20, 0, 0, "R10", 0, lat);
        for (int i = 0; i < 6; i++) do_op(3'd2, 0, 0, 0, "R3", 0, lat);
        do_op(3'd5, 16'h90, 0, 0, "R10", 0, lat);
        check("R10", "memory untouched by refused double pop", 32'(mem[8'h91]), 32'(16'h0091 ^ 16'h5A00));

        repeat (3) @(negedge clk);
        check("R11", "scoreboard drained", 32'(sb.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule